// File: doc/BRIEF.md
# Byte-Lane Parity Check and Generate Unit

This unit sits beside one 36-bit data port. The port word is split into four 9-bit byte lanes. In each lane the top bit is the parity bit and the eight bits below it are data. On words coming in from the bus, the unit checks every lane against the parity type picked by an odd/even select. It drives an active-low error flag whenever any lane fails. The flag is available both as a combinational output and as a copy registered on the port clock.

On words going out as read data, the unit can replace each lane's top bit with freshly computed parity of the selected type. With generation off, the read word passes through untouched.

The parity trees that check the incoming bus are also used to generate parity for mailbox reads. When a mailbox read with generation is set up, those trees are busy, so the error flag is held inactive whatever the bus carries. Ordinary (non-mailbox) reads use a second set of trees, so checking carries on during them.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane k (k = 0..3) occupies word bits 9k+8 down to 9k. Bit 9k+8 is that lane's parity bit and bits 9k+7..9k are its data.
- R2: With odd_sel = 1 a lane passes when the XOR of all nine of its bits is 1. With odd_sel = 0 it passes when that XOR is 0.
- R3: Outside the forced case of R6, perr_n is 0 exactly when at least one lane of bus_in fails the selected parity, and is 1 otherwise.
- R4: During a read with generation (wr_sel = 0, gen_en = 1), rd_out equals rd_data in every lane data bit, and each lane parity bit is replaced by a generated bit.
- R5: The generated bit of a lane is the XOR of that lane's eight data bits, inverted when odd_sel = 1. The same odd_sel sets the parity type for both checking and generation.
- R6: When wr_sel = 0, mbox_sel = 1 and gen_en = 1, perr_n is 1 whatever bus_in holds.
- R7: When gen_en = 0 or wr_sel = 1, rd_out equals rd_data bit for bit, parity bits included.
- R8: perr_n_q takes the value of perr_n on every rising clock edge. It is 1 after a clock edge with rst_n = 0 (synchronous active-low reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 36 | Word arriving from the port bus, checked for parity |
| rd_data | input | 36 | Read word from storage or mailbox, before parity insertion |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| gen_en | input | 1 | Enables parity generation on reads |
| wr_sel | input | 1 | 1 selects a write, 0 selects a read |
| mbox_sel | input | 1 | 1 selects the mailbox path for the current access |
| perr_n | output | 1 | Combinational active-low parity error flag |
| perr_n_q | output | 1 | Registered copy of perr_n |
| rd_out | output | 36 | Read word after optional parity insertion |

## Verification
The embedded properties check on every clock edge that:
- the flag is held high during a mailbox read with generation;
- read data passes through untouched when generation is off;
- lane data bits are never altered;
- every generated lane satisfies the selected parity;
- the registered flag follows the combinational one by one cycle.

Whether the flag drops for a single corrupted lane in each position, and whether it stays high for clean words of either parity type, is shown only by the bench's directed and random words compared against its own model. The reset value of the registered flag while the bus carries bad parity is also shown only by the bench.

// File: rtl/lpu_pkg.sv
// Package: shared geometry of the byte-lane parity unit.
// Assumes every lane carries its parity bit in its most significant position.
package lpu_pkg;
    parameter int LANES  = 4;
    parameter int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
endpackage

// File: rtl/lpu_lane_tree.sv
// Module: parity tree for one lane.
// Produces the parity bit that the lane's data bits call for under the selected
// parity type. Assumes the top bit of the lane is the parity slot and is excluded.
module lpu_lane_tree #(
    parameter int LANE_W = lpu_pkg::LANE_W
) (
    input  logic [LANE_W-1:0] lane,
    input  logic              odd_sel,
    output logic              par_bit
);
    localparam int DATA_W = LANE_W - 1;

    logic [DATA_W-1:0] data_bits;

    // Purpose: XOR-reduce the data bits and invert the result for odd parity.
    always_comb begin
        data_bits = lane[DATA_W-1:0];
        par_bit   = (^data_bits) ^ odd_sel;
    end
endmodule

// File: rtl/lpu_word_parity.sv
// Module: one set of lane parity trees covering a full word.
// Assumes lanes are packed upward from bit 0, LANE_W bits each.
module lpu_word_parity #(
    parameter int LANES  = lpu_pkg::LANES,
    parameter int LANE_W = lpu_pkg::LANE_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              odd_sel,
    output logic [LANES-1:0]  par_bits
);
    // Purpose: one tree per lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lpu_lane_tree #(.LANE_W(LANE_W)) u_tree (
            .lane    (word[k*LANE_W +: LANE_W]),
            .odd_sel (odd_sel),
            .par_bit (par_bits[k])
        );
    end
endmodule

// File: rtl/lpu_insert.sv
// Module: writes generated parity into each lane's top bit when enabled.
// Assumes data bits below each lane's top bit are never modified.
module lpu_insert #(
    parameter int LANES  = lpu_pkg::LANES,
    parameter int LANE_W = lpu_pkg::LANE_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [LANES-1:0]  par_bits,
    input  logic              enable,
    output logic [WORD_W-1:0] word_out
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Purpose: keep the data bits, choose the parity slot source.
        always_comb begin
            word_out[k*LANE_W +: LANE_W-1] = word_in[k*LANE_W +: LANE_W-1];
            word_out[k*LANE_W + LANE_W-1]  = enable ? par_bits[k]
                                                    : word_in[k*LANE_W + LANE_W-1];
        end
    end
endmodule

// File: rtl/lpu_check.sv
// Module: turns per-lane expected parity into the active-low error flag, with
// a registered copy. Assumes par_bits were computed from the same word.
module lpu_check #(
    parameter int LANES  = lpu_pkg::LANES,
    parameter int LANE_W = lpu_pkg::LANE_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic [LANES-1:0]  par_bits,
    input  logic              force_ok,
    output logic              err_n,
    output logic              err_n_q
);
    logic [LANES-1:0] lane_bad;

    // Purpose: a lane fails when its parity slot differs from the expected bit.
    for (genvar k = 0; k < LANES; k++) begin : g_cmp
        assign lane_bad[k] = word[k*LANE_W + LANE_W-1] ^ par_bits[k];
    end

    // Purpose: combine the lanes unless the trees are lent out for generation.
    always_comb begin
        err_n = force_ok | ~(|lane_bad);
    end

    // Purpose: registered copy of the flag, inactive (high) after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err_n_q <= 1'b1;
        else        err_n_q <= err_n;
    end

    // R8: the registered flag follows the combinational one by one cycle
    p_reg_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> err_n_q == $past(err_n));
endmodule

// File: rtl/lane_parity_unit.sv
// Module: byte-lane parity checker and generator for one 36-bit port.
// One tree set checks the bus and is borrowed for mailbox-read generation;
// a second tree set serves ordinary reads. Assumes wr_sel=1 means write.
module lane_parity_unit #(
    parameter int LANES  = lpu_pkg::LANES,
    parameter int LANE_W = lpu_pkg::LANE_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] bus_in,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              odd_sel,
    input  logic              gen_en,
    input  logic              wr_sel,
    input  logic              mbox_sel,
    output logic              perr_n,
    output logic              perr_n_q,
    output logic [WORD_W-1:0] rd_out
);
    logic              gen_rd;
    logic              share_mode;
    logic [WORD_W-1:0] tree_in;
    logic [LANES-1:0]  shared_par;
    logic [LANES-1:0]  fifo_par;
    logic [LANES-1:0]  ins_par;

    // Purpose: decode the access type and steer the shared trees.
    always_comb begin
        gen_rd     = ~wr_sel & gen_en;
        share_mode = gen_rd & mbox_sel;
        tree_in    = share_mode ? rd_data : bus_in;
        ins_par    = mbox_sel ? shared_par : fifo_par;
    end

    lpu_word_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_shared (
        .word     (tree_in),
        .odd_sel  (odd_sel),
        .par_bits (shared_par)
    );

    lpu_word_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_fifo (
        .word     (rd_data),
        .odd_sel  (odd_sel),
        .par_bits (fifo_par)
    );

    lpu_check #(.LANES(LANES), .LANE_W(LANE_W)) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .word     (tree_in),
        .par_bits (shared_par),
        .force_ok (share_mode),
        .err_n    (perr_n),
        .err_n_q  (perr_n_q)
    );

    lpu_insert #(.LANES(LANES), .LANE_W(LANE_W)) u_insert (
        .word_in  (rd_data),
        .par_bits (ins_par),
        .enable   (gen_rd),
        .word_out (rd_out)
    );

    // R6: a mailbox read with generation holds the flag inactive
    p_forced_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sel && mbox_sel && gen_en) |-> perr_n);

    // R7: without generation on a read, the read word is passed untouched
    p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel || !gen_en) |-> rd_out == rd_data);

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R4: lane data bits are never altered
        p_data_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_out[k*LANE_W +: LANE_W-1] == rd_data[k*LANE_W +: LANE_W-1]);
        // R5: a generated lane satisfies the selected parity type
        p_gen_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_sel && gen_en) |-> (^rd_out[k*LANE_W +: LANE_W]) == odd_sel);
    end
endmodule

// File: tb/sim_lane_parity_unit.sv
module sim_lane_parity_unit;
    localparam int L = 4;
    localparam int W = 9;
    localparam int WW = L * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] bus_in = '0;
    logic [WW-1:0] rd_data = '0;
    logic          odd_sel = 1'b0;
    logic          gen_en = 1'b0;
    logic          wr_sel = 1'b1;
    logic          mbox_sel = 1'b0;
    logic          perr_n, perr_n_q;
    logic [WW-1:0] rd_out;

    int  n_vec = 0;
    int  n_bad = 0;
    logic exp_q = 1'b1;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    lane_parity_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .rd_data(rd_data),
        .odd_sel(odd_sel), .gen_en(gen_en), .wr_sel(wr_sel), .mbox_sel(mbox_sel),
        .perr_n(perr_n), .perr_n_q(perr_n_q), .rd_out(rd_out)
    );

    // Model of R1/R2/R3/R6.
    function automatic logic model_perr(logic [WW-1:0] b, logic o, logic g, logic w, logic m);
        if (!w && m && g) return 1'b1;
        for (int k = 0; k < L; k++)
            if ((^b[k*W +: W]) != o) return 1'b0;
        return 1'b1;
    endfunction

    // Model of R4/R5/R7.
    function automatic logic [WW-1:0] model_out(logic [WW-1:0] r, logic o, logic g, logic w);
        logic [WW-1:0] x = r;
        if (g && !w)
            for (int k = 0; k < L; k++)
                x[k*W + W-1] = (^r[k*W +: W-1]) ^ o;
        return x;
    endfunction

    // Builds a word whose every lane satisfies the requested parity.
    function automatic logic [WW-1:0] clean_word(logic [WW-1:0] r, logic o);
        return model_out(r, o, 1'b1, 1'b0);
    endfunction

    task automatic check(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one vector at the falling edge; check the registered flag from the
    // previous edge first, then the combinational outputs.
    task automatic apply(logic [WW-1:0] b, logic [WW-1:0] r, logic o, logic g,
                         logic w, logic m, string req);
        @(negedge clk);
        check("R8 registered flag", {35'd0, perr_n_q}, {35'd0, exp_q});
        bus_in = b; rd_data = r; odd_sel = o; gen_en = g; wr_sel = w; mbox_sel = m;
        #1;
        check(req, {35'd0, perr_n}, {35'd0, model_perr(b, o, g, w, m)});
        check(req, rd_out, model_out(r, o, g, w));
        exp_q = model_perr(b, o, g, w, m);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] base;
        void'($urandom(32'd1234));
        // R8: reset with a bad bus word; registered flag must still read 1
        bus_in = 36'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset value", {35'd0, perr_n_q}, 36'd1);
        rst_n = 1'b1;
        exp_q = model_perr(bus_in, odd_sel, gen_en, wr_sel, mbox_sel);

        // R2: all-zero word passes even, fails odd on every lane
        apply('0, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R2 even zero");
        apply('0, '0, 1'b1, 1'b0, 1'b1, 1'b0, "R2 odd zero");
        // R1/R3: single lane corruption in each lane position, both types
        for (int o = 0; o < 2; o++) begin
            base = clean_word(36'h5_A3C_F019, o[0]);
            apply(base, '0, o[0], 1'b0, 1'b1, 1'b0, "R3 clean word");
            for (int k = 0; k < L; k++) begin
                apply(base ^ (36'd1 << (k*W + W-1)), '0, o[0], 1'b0, 1'b1, 1'b0, "R1 R3 lane parity bit");
                apply(base ^ (36'd1 << (k*W)), '0, o[0], 1'b0, 1'b1, 1'b0, "R1 R3 lane data bit");
            end
        end
        // R6: mailbox read with generation masks a bad bus; non-mailbox does not
        apply('0, 36'hF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b1, "R6 forced high");
        apply('0, 36'hF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R3 R4 fifo read gen");
        // R5: known generated values
        apply('0, 36'h0_0000_0001, 1'b0, 1'b1, 1'b0, 1'b0, "R5 even gen");
        apply('0, 36'h0_0000_0000, 1'b1, 1'b1, 1'b0, 1'b1, "R5 odd gen mailbox");
        // R7: generation ignored on writes and when disabled
        apply('0, 36'hA_BCDE_F012, 1'b1, 1'b1, 1'b1, 1'b1, "R7 write ignores gen");
        apply('0, 36'hA_BCDE_F012, 1'b0, 1'b0, 1'b0, 1'b1, "R7 gen off");

        // Random mix, half the bus words clean
        for (int i = 0; i < 3000; i++) begin
            logic [WW-1:0] b, r;
            logic o;
            o = 1'($urandom);
            b = WW'({$urandom(), $urandom()});
            r = WW'({$urandom(), $urandom()});
            if ($urandom % 2 == 0) b = clean_word(b, o);
            apply(b, r, o, 1'($urandom), 1'($urandom), 1'($urandom), "R2 R3 R4 R5 R6 R7 random");
        end
        @(negedge clk);
        check("R8 registered flag", {35'd0, perr_n_q}, {35'd0, exp_q});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule